// File: doc/BRIEF.md
# SD Card SPI Single-Block Write Data Phase

This block takes over an SD card's SPI link once a write command has been answered with a clean R1 byte (0x00) and chip select is still low. It sends the data start token, moves the payload from a byte stream onto the link, and appends a 16-bit CRC that it builds as the bytes go by. It then reads the card's data-response byte, decides whether the card took the block, and polls through the card's busy period. Every run, successful or not, ends by raising chip select and clocking one idle 0xFF byte so the card releases the data line.

The link is reached through a byte-exchange handshake. The engine holds a request with a transmit byte, and a serializer returns an acknowledge pulse together with the byte it clocked in. The payload arrives on a valid/ready stream. The engine never sends filler bytes to cover a gap in the stream; it simply holds the link until the next byte is there. The outcome is reported by a one-cycle done pulse with a status code and the card's 3-bit response code. A start that arrives while a run is in progress is refused with a separate one-cycle pulse and has no effect on the run.

Top module: `sd_wr_engine`

## Requirements
- R1: After reset, cs_n_o is 1, busy_o, done_o, xfer_req_o, pay_ready_o and refuse_o are 0.
- R2: A start with a non-zero R1 byte sends no token and takes no payload. Chip select stays high, exactly one 0xFF byte is exchanged, and done_o then reports status 1 (bad R1).
- R3: With R1 equal to 0x00, the bytes exchanged with cs_n_o low are, in order: 0xFE, the payload bytes in arrival order, the CRC high byte, the CRC low byte, one 0xFF for the data response, and then 0xFF for each busy poll.
- R4: The CRC uses the polynomial 0x1021, starts from zero, and runs MSB first over the payload bytes only. The ASCII payload "123456789" gives 0x31C3.
- R5: Exactly the requested number of payload bytes is taken. Each byte taken is requested on the link on the next cycle. While the stream has no data, no exchange is requested.
- R6: The write is accepted only when bits 4:0 of the response byte are 00101. Otherwise the run ends with status 2 (rejected), with no busy polling, and resp_code_o holds bits 3:1 of the response byte. resp_code_o carries those bits on acceptance too.
- R7: After acceptance, the engine exchanges 0xFF until a non-zero byte is returned, and then ends with status 0 (ok).
- R8: At most POLL_MAX polls (default 8192) are made. If all of them return 0x00, the status is 3 (timeout). A non-zero byte on the last allowed poll still gives status 0.
- R9: Every run closes with exactly one 0xFF exchange while cs_n_o is 1. On the cycle after that exchange is acknowledged, done_o pulses for one cycle with status_o valid and busy_o low.
- R10: A start while busy_o is 1 produces a one-cycle refuse_o pulse on the next cycle and does not disturb the run in progress.
- R11: While xfer_req_o is 1 and no acknowledge has arrived, xfer_req_o stays 1 and xfer_tx_o does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a write data phase |
| start_len_i | input | LEN_W | Payload length in bytes |
| start_r1_i | input | 8 | R1 byte returned by the command |
| pay_data_i | input | 8 | Payload byte |
| pay_valid_i | input | 1 | Payload byte valid |
| pay_ready_o | output | 1 | Payload byte accepted when valid is also high |
| xfer_req_o | output | 1 | Byte exchange request |
| xfer_tx_o | output | 8 | Byte to transmit |
| xfer_ack_i | input | 1 | Exchange complete, one-cycle pulse |
| xfer_rx_i | input | 8 | Byte received, valid with xfer_ack_i |
| cs_n_o | output | 1 | Card chip select, active low |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | Run finished, one-cycle pulse |
| status_o | output | 2 | 0 ok, 1 bad R1, 2 rejected, 3 busy timeout |
| resp_code_o | output | 3 | Bits 3:1 of the last data-response byte |
| refuse_o | output | 1 | Start refused because the engine was busy |

## Verification
The hardest situation to reach is the end of the busy poll window, where a zero on the final allowed poll must give a timeout and a non-zero byte on that same poll must still give success. The bench's link model returns a scripted list of received bytes, one per exchange. It scripts exactly POLL_MAX zero bytes for one run and POLL_MAX-1 zeros followed by a non-zero byte for another, so both sides of the boundary are driven at the default limit. Gaps in the payload stream and a start issued in the middle of a run are driven from the same model, so stalling and refusal are checked against the exact byte sequence on the link.

// File: rtl/sd_wr_pkg.sv
package sd_wr_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_TOKEN, S_DATA, S_CRC_HI, S_CRC_LO, S_RESP, S_POLL, S_CLOSE
  } wr_state_e;

  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_BAD_R1  = 2'd1,
    ST_REJECT  = 2'd2,
    ST_TIMEOUT = 2'd3
  } wr_status_e;

  localparam logic [7:0]  START_TOKEN = 8'hFE;
  localparam logic [7:0]  FILL_BYTE   = 8'hFF;
  localparam logic [4:0]  RESP_OK     = 5'b00101;
  localparam logic [15:0] CRC_POLY    = 16'h1021;

  function automatic logic [15:0] crc16_step(input logic [15:0] crc, input logic [7:0] b);
    logic [15:0] c;
    c = crc ^ {b, 8'h00};
    for (int i = 0; i < 8; i++) begin
      c = c[15] ? ((c << 1) ^ CRC_POLY) : (c << 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/sd_wr_crc16.sv
module sd_wr_crc16 (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        upd_i,
  input  logic [7:0]  byte_i,
  output logic [15:0] crc_o
);
  import sd_wr_pkg::*;

  logic [15:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= '0;
    else if (clr_i)  crc_q <= '0;
    else if (upd_i)  crc_q <= crc16_step(crc_q, byte_i);
  end

  assign crc_o = crc_q;

  a_r4_crc_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> crc_o == 16'h0000);

  a_r4_crc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i && !upd_i |=> $stable(crc_o));

endmodule

// File: rtl/sd_wr_poll_cnt.sv
module sd_wr_poll_cnt #(
  parameter int POLL_MAX = 8192
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int CNT_W = (POLL_MAX > 1) ? $clog2(POLL_MAX) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(POLL_MAX - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == CNT_LAST);

  // R8: the count never passes the last allowed poll
  a_r8_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |-> !last_o);

endmodule

// File: rtl/sd_wr_fsm.sv
module sd_wr_fsm #(
  parameter int LEN_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [7:0]       r1_i,
  input  logic [7:0]       pay_data_i,
  input  logic             pay_valid_i,
  output logic             pay_ready_o,
  output logic             xfer_req_o,
  output logic [7:0]       xfer_tx_o,
  input  logic             xfer_ack_i,
  input  logic [7:0]       xfer_rx_i,
  input  logic [15:0]      crc_i,
  output logic             crc_clr_o,
  output logic             crc_upd_o,
  output logic [7:0]       crc_byte_o,
  output logic             poll_clr_o,
  output logic             poll_inc_o,
  input  logic             poll_last_i,
  output logic             cs_n_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [1:0]       status_o,
  output logic [2:0]       resp_code_o,
  output logic             refuse_o
);
  import sd_wr_pkg::*;

  wr_state_e        state_q;
  logic [LEN_W-1:0] rem_q;
  logic [7:0]       hold_q;
  logic             hold_vld_q;
  logic             done_q, refuse_q;
  wr_status_e       status_q;
  logic [2:0]       code_q;

  logic ack, take, accept, resp_ok, rx_zero;

  assign ack     = xfer_ack_i && xfer_req_o;
  assign accept  = start_i && (state_q == S_IDLE);
  assign resp_ok = (xfer_rx_i[4:0] == RESP_OK);
  assign rx_zero = (xfer_rx_i == 8'h00);

  always_comb begin
    xfer_req_o = 1'b1;
    xfer_tx_o  = FILL_BYTE;
    unique case (state_q)
      S_IDLE:   xfer_req_o = 1'b0;
      S_TOKEN:  xfer_tx_o  = START_TOKEN;
      S_DATA: begin
        xfer_req_o = hold_vld_q;
        xfer_tx_o  = hold_q;
      end
      S_CRC_HI: xfer_tx_o  = crc_i[15:8];
      S_CRC_LO: xfer_tx_o  = crc_i[7:0];
      default:  xfer_tx_o  = FILL_BYTE;
    endcase
  end

  assign pay_ready_o = (state_q == S_DATA) && !hold_vld_q;
  assign take        = pay_ready_o && pay_valid_i;

  assign crc_clr_o  = accept;
  assign crc_upd_o  = (state_q == S_DATA) && ack;
  assign crc_byte_o = hold_q;
  assign poll_clr_o = (state_q == S_RESP);
  assign poll_inc_o = (state_q == S_POLL) && ack && rx_zero && !poll_last_i;

  assign cs_n_o = (state_q == S_IDLE) || (state_q == S_CLOSE);
  assign busy_o = (state_q != S_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      rem_q      <= '0;
      hold_q     <= '0;
      hold_vld_q <= 1'b0;
      done_q     <= 1'b0;
      refuse_q   <= 1'b0;
      status_q   <= ST_OK;
      code_q     <= '0;
    end else begin
      done_q   <= (state_q == S_CLOSE) && ack;
      refuse_q <= start_i && (state_q != S_IDLE);
      if (take) begin
        hold_q     <= pay_data_i;
        hold_vld_q <= 1'b1;
      end else if (crc_upd_o) begin
        hold_vld_q <= 1'b0;
      end
      unique case (state_q)
        S_IDLE: if (accept) begin
          rem_q <= len_i;
          if (r1_i == 8'h00) begin
            state_q <= S_TOKEN;
          end else begin
            status_q <= ST_BAD_R1;
            state_q  <= S_CLOSE;
          end
        end
        S_TOKEN: if (ack) state_q <= (rem_q == '0) ? S_CRC_HI : S_DATA;
        S_DATA: if (ack) begin
          if (rem_q == LEN_W'(1)) state_q <= S_CRC_HI;
          rem_q <= rem_q - 1'b1;
        end
        S_CRC_HI: if (ack) state_q <= S_CRC_LO;
        S_CRC_LO: if (ack) state_q <= S_RESP;
        S_RESP: if (ack) begin
          code_q <= xfer_rx_i[3:1];
          if (resp_ok) begin
            state_q <= S_POLL;
          end else begin
            status_q <= ST_REJECT;
            state_q  <= S_CLOSE;
          end
        end
        S_POLL: if (ack) begin
          if (!rx_zero) begin
            status_q <= ST_OK;
            state_q  <= S_CLOSE;
          end else if (poll_last_i) begin
            status_q <= ST_TIMEOUT;
            state_q  <= S_CLOSE;
          end
        end
        S_CLOSE: if (ack) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign done_o      = done_q;
  assign refuse_o    = refuse_q;
  assign status_o    = status_q;
  assign resp_code_o = code_q;

  a_r11_tx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_req_o && !xfer_ack_i |=> xfer_req_o && $stable(xfer_tx_o));

  a_r5_take_sent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pay_valid_i && pay_ready_o |=> xfer_req_o && xfer_tx_o == $past(pay_data_i));

  a_r2_bad_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && r1_i != 8'h00 |=> busy_o && cs_n_o);

  a_r10_refuse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && busy_o |=> refuse_o);

  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

endmodule

// File: rtl/sd_wr_engine.sv
module sd_wr_engine #(
  parameter int LEN_W    = 10,
  parameter int POLL_MAX = 8192
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] start_len_i,
  input  logic [7:0]       start_r1_i,
  input  logic [7:0]       pay_data_i,
  input  logic             pay_valid_i,
  output logic             pay_ready_o,
  output logic             xfer_req_o,
  output logic [7:0]       xfer_tx_o,
  input  logic             xfer_ack_i,
  input  logic [7:0]       xfer_rx_i,
  output logic             cs_n_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [1:0]       status_o,
  output logic [2:0]       resp_code_o,
  output logic             refuse_o
);

  logic [15:0] crc;
  logic        crc_clr, crc_upd;
  logic [7:0]  crc_byte;
  logic        poll_clr, poll_inc, poll_last;

  sd_wr_crc16 u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (crc_clr),
    .upd_i  (crc_upd),
    .byte_i (crc_byte),
    .crc_o  (crc)
  );

  sd_wr_poll_cnt #(.POLL_MAX(POLL_MAX)) u_poll (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (poll_clr),
    .inc_i  (poll_inc),
    .last_o (poll_last)
  );

  sd_wr_fsm #(.LEN_W(LEN_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .len_i       (start_len_i),
    .r1_i        (start_r1_i),
    .pay_data_i  (pay_data_i),
    .pay_valid_i (pay_valid_i),
    .pay_ready_o (pay_ready_o),
    .xfer_req_o  (xfer_req_o),
    .xfer_tx_o   (xfer_tx_o),
    .xfer_ack_i  (xfer_ack_i),
    .xfer_rx_i   (xfer_rx_i),
    .crc_i       (crc),
    .crc_clr_o   (crc_clr),
    .crc_upd_o   (crc_upd),
    .crc_byte_o  (crc_byte),
    .poll_clr_o  (poll_clr),
    .poll_inc_o  (poll_inc),
    .poll_last_i (poll_last),
    .cs_n_o      (cs_n_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .status_o    (status_o),
    .resp_code_o (resp_code_o),
    .refuse_o    (refuse_o)
  );

  a_r9_close_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cs_n_o && !busy_o);

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !xfer_req_o && !pay_ready_o);

endmodule

// File: tb/sd_wr_engine_tb_top.sv
module sd_wr_engine_tb_top;
  localparam int LEN_W    = 10;
  localparam int POLL_MAX = 8192;
  localparam int SPI_DLY  = 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [LEN_W-1:0] start_len_i = '0;
  logic [7:0] start_r1_i = '0;
  logic [7:0] pay_data_i = '0;
  logic pay_valid_i = 1'b0;
  logic xfer_ack_i = 1'b0;
  logic [7:0] xfer_rx_i = '0;
  logic pay_ready_o, xfer_req_o, cs_n_o, busy_o, done_o, refuse_o;
  logic [7:0] xfer_tx_o;
  logic [1:0] status_o;
  logic [2:0] resp_code_o;

  always #2 clk = ~clk;

  sd_wr_engine #(.LEN_W(LEN_W), .POLL_MAX(POLL_MAX)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .start_len_i(start_len_i),
    .start_r1_i(start_r1_i), .pay_data_i(pay_data_i), .pay_valid_i(pay_valid_i),
    .pay_ready_o(pay_ready_o), .xfer_req_o(xfer_req_o), .xfer_tx_o(xfer_tx_o),
    .xfer_ack_i(xfer_ack_i), .xfer_rx_i(xfer_rx_i), .cs_n_o(cs_n_o), .busy_o(busy_o),
    .done_o(done_o), .status_o(status_o), .resp_code_o(resp_code_o), .refuse_o(refuse_o)
  );

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  int pay_taken = 0;
  int n_bytes = 0;
  bit gaps = 1'b0;

  logic [8:0] exp_q[$];   // {cs_n, byte}
  logic [7:0] rx_q[$];
  logic [7:0] pay_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [7:0] d[$]);
    logic [15:0] c = 16'h0000;
    foreach (d[k]) begin
      for (int b = 7; b >= 0; b--) begin
        logic fb = c[15] ^ d[k][b];
        c = {c[14:0], 1'b0};
        if (fb) c = c ^ 16'h1021;
      end
    end
    return c;
  endfunction

  // watchdog
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 190000) begin
        check(1'b0, "R9", "watchdog expired", cyc, 0);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
      end
    end
  end

  // link model: scripted rx bytes, checks tx byte and chip select per exchange
  initial begin
    int dly = 0;
    forever begin
      @(negedge clk);
      if (xfer_ack_i) begin
        xfer_ack_i = 1'b0;
      end else if (xfer_req_o && rst_ni) begin
        if (dly < SPI_DLY) dly++;
        else begin
          logic [8:0] e;
          dly = 0;
          xfer_ack_i = 1'b1;
          xfer_rx_i = (rx_q.size() != 0) ? rx_q.pop_front() : 8'hFF;
          n_bytes++;
          if (exp_q.size() == 0) begin
            check(1'b0, "R3", "unexpected exchange", {cs_n_o, xfer_tx_o}, 0);
          end else begin
            e = exp_q.pop_front();
            if ({cs_n_o, xfer_tx_o} != e) begin
              n_checks++; n_fail++;
              $display("FAIL R3 byte %0d {cs_n,tx}: actual 0x%0h expected 0x%0h",
                       n_bytes, {cs_n_o, xfer_tx_o}, e);
            end
          end
        end
      end
    end
  end

  // payload source with optional gaps; valid never drops before transfer
  initial begin
    bit fire = 1'b0;
    forever begin
      @(negedge clk);
      if (fire) begin
        void'(pay_q.pop_front());
        pay_taken++;
        pay_valid_i = 1'b0;
      end
      if (!pay_valid_i && pay_q.size() != 0 && !(gaps && (cyc % 4 != 0))) begin
        pay_valid_i = 1'b1;
        pay_data_i  = pay_q[0];
      end
      fire = pay_valid_i && pay_ready_o;
    end
  end

  task automatic wait_done(input int st, input bit chk_code, input int code, input string req);
    bit seen = 1'b0;
    for (int i = 0; i < 40000 && !seen; i++) begin
      @(negedge clk);
      if (done_o) begin
        seen = 1'b1;
        check(status_o == st[1:0], req, "status", status_o, st);
        check(!busy_o && cs_n_o, "R9", "idle at done", {busy_o, cs_n_o}, 1);
        if (chk_code) check(resp_code_o == code[2:0], "R6", "resp code", resp_code_o, code);
      end
    end
    check(seen, "R9", "done pulse seen", seen, 1);
    @(negedge clk);
    check(!done_o, "R9", "done one cycle", done_o, 0);
    check(exp_q.size() == 0, "R3", "bytes left unsent", exp_q.size(), 0);
  endtask

  // build scripts and run one write
  task automatic run_write(input int len, input logic [7:0] r1, input logic [7:0] resp,
                           input int zeros, input bit term, input logic [7:0] pl[$],
                           input bit refuse_mid);
    logic [15:0] c;
    bit ok_r1 = (r1 == 8'h00);
    bit ok_resp = (resp[4:0] == 5'b00101);
    exp_q.delete(); rx_q.delete(); pay_q.delete();
    pay_taken = 0;
    if (ok_r1) begin
      c = ref_crc(pl);
      exp_q.push_back({1'b0, 8'hFE}); rx_q.push_back(8'hFF);
      foreach (pl[k]) begin
        exp_q.push_back({1'b0, pl[k]}); rx_q.push_back(8'hFF);
        pay_q.push_back(pl[k]);
      end
      exp_q.push_back({1'b0, c[15:8]}); rx_q.push_back(8'hFF);
      exp_q.push_back({1'b0, c[7:0]});  rx_q.push_back(8'hFF);
      exp_q.push_back({1'b0, 8'hFF});   rx_q.push_back(resp);
      if (ok_resp) begin
        for (int k = 0; k < zeros; k++) begin
          exp_q.push_back({1'b0, 8'hFF}); rx_q.push_back(8'h00);
        end
        if (term) begin
          exp_q.push_back({1'b0, 8'hFF}); rx_q.push_back(8'h01);
        end
      end
    end
    exp_q.push_back({1'b1, 8'hFF}); rx_q.push_back(8'hFF);
    @(negedge clk);
    start_i = 1'b1; start_len_i = LEN_W'(len); start_r1_i = r1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o, "R1", "busy after start", busy_o, 1);
    if (refuse_mid) begin
      repeat (6) @(negedge clk);
      start_i = 1'b1; start_r1_i = 8'h00;
      @(negedge clk);
      start_i = 1'b0;
      check(refuse_o, "R10", "refuse pulse", refuse_o, 1);
      @(negedge clk);
      check(!refuse_o, "R10", "refuse one cycle", refuse_o, 0);
    end
  endtask

  initial begin
    logic [7:0] pl[$];
    repeat (4) @(negedge clk);
    check(cs_n_o && !busy_o && !done_o && !xfer_req_o && !pay_ready_o && !refuse_o,
          "R1", "reset outputs", {cs_n_o, busy_o, done_o, xfer_req_o, pay_ready_o, refuse_o}, 6'h20);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check(cs_n_o && !busy_o && !xfer_req_o, "R1", "idle after reset",
          {cs_n_o, busy_o, xfer_req_o}, 3'b100);

    // R2: bad R1
    pl.delete();
    run_write(4, 8'h01, 8'h00, 0, 1'b0, pl, 1'b0);
    wait_done(1, 1'b0, 0, "R2");
    check(pay_taken == 0, "R2", "payload untouched", pay_taken, 0);

    // R3 R6 R7: plain write, accepted with high bits set, short busy
    pl.delete();
    for (int k = 0; k < 4; k++) pl.push_back(8'h3C + 8'(k * 17));
    run_write(4, 8'h00, 8'hE5, 3, 1'b1, pl, 1'b0);
    wait_done(0, 1'b1, 2, "R7");
    check(pay_taken == 4, "R5", "bytes taken", pay_taken, 4);

    // R5 R6 R10: gapped stream, rejected, start in the middle refused
    gaps = 1'b1;
    pl.delete();
    for (int k = 0; k < 6; k++) pl.push_back(8'hA1 ^ 8'(k * 29));
    run_write(6, 8'h00, 8'h0B, 0, 1'b0, pl, 1'b1);
    wait_done(2, 1'b1, 5, "R6");
    check(pay_taken == 6, "R5", "bytes taken with gaps", pay_taken, 6);
    gaps = 1'b0;

    // R4: known check value
    pl.delete();
    for (int k = 0; k < 9; k++) pl.push_back(8'h31 + 8'(k));
    check(ref_crc(pl) == 16'h31C3, "R4", "check value", ref_crc(pl), 16'h31C3);
    run_write(9, 8'h00, 8'h05, 0, 1'b1, pl, 1'b0);
    wait_done(0, 1'b1, 2, "R4");

    // R6: other reject code
    pl.delete(); pl.push_back(8'h00); pl.push_back(8'hFF);
    run_write(2, 8'h00, 8'h0D, 0, 1'b0, pl, 1'b0);
    wait_done(2, 1'b1, 6, "R6");

    // R8: all polls zero -> timeout
    pl.delete(); pl.push_back(8'h5A);
    run_write(1, 8'h00, 8'h05, POLL_MAX, 1'b0, pl, 1'b0);
    wait_done(3, 1'b0, 0, "R8");

    // R8: release on the last allowed poll -> ok
    pl.delete(); pl.push_back(8'h12); pl.push_back(8'h34);
    run_write(2, 8'h00, 8'h05, POLL_MAX - 1, 1'b1, pl, 1'b0);
    wait_done(0, 1'b1, 2, "R8");

    repeat (3) @(negedge clk);
    check(!busy_o && cs_n_o && !xfer_req_o, "R1", "idle at end",
          {busy_o, cs_n_o, xfer_req_o}, 3'b010);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule